// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works out where the two operands of an instruction live, for a 16-bit two-operand machine with eight registers and eight addressing modes. When the decoder hands it the source and destination mode/register fields together with a byte-or-word flag, it runs through a fixed sequence. The sequence resolves the source operand first and the destination operand second. For each operand it produces a descriptor: either "this operand is register N" or "this operand is at memory address A".

While the sequence runs, the block drives the machine's register file through one combinational read port and one write port. Auto-increment and auto-decrement results go back into the register file as soon as their operand has been decoded. Index words and indirect pointers are read through a 16-bit memory read port that allows only one request in flight. A one-cycle done strobe tells the execute stage that both descriptors are ready. The descriptors then stay unchanged until the next accepted start.

Mode field encoding, shared by both operands: 0 register, 1 register indirect, 2 post-increment, 3 post-increment indirect, 4 pre-decrement, 5 pre-decrement indirect, 6 indexed, 7 indexed indirect. The stack register is R6 and the instruction pointer is R7.

Top module: `opnd_addr_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, busy, done, mem_req and reg_wr_en are all low.
- R2: Mode 0 yields a register descriptor (is_reg high, sel equal to the register field). It performs no register write and no memory read for that operand.
- R3: Mode 1 yields the address held in the register and leaves the register unchanged.
- R4: Modes 2 and 3 use the register's old value as the address (mode 2) or as the pointer location (mode 3), and write back old value plus the step. Mode 2 on R7 therefore addresses the word following the instruction pointer.
- R5: Modes 4 and 5 first write back register minus the step, then use the new value as the address (mode 4) or as the pointer location (mode 5).
- R6: The step is 1 for byte operations on R0 to R5 in modes 2 and 4. It is 2 for word operations, for R6 and R7 in every case, and for the indirect modes 3 and 5.
- R7: Modes 6 and 7 read an index word at R7, advance R7 by 2, and then add the index to the register's value. When the register is R7 itself, the advanced value is the one used.
- R8: The indirect modes 3, 5 and 7 read a 16-bit pointer at the computed location, and that pointer becomes the operand address.
- R9: The source operand, including its register write-back, is completely resolved before the destination operand is decoded. If both operands use the same register, the destination sees the source's update.
- R10: Word operand addresses have bit 0 cleared, while byte operand addresses keep it. Every memory read address is even, because odd read addresses are aligned down.
- R11: done is high for exactly one cycle per sequence. A start seen while busy is ignored. Descriptors stay stable after done until the next accepted start.
- R12: Once mem_req is raised, it stays high with an unchanged mem_addr until a cycle with mem_ack. A new request is never raised while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence with the current fields (accepted when idle) |
| byte_op | input | 1 | 1 for a byte operation, 0 for a word operation |
| src_mode | input | 3 | Source addressing mode |
| src_reg | input | 3 | Source register number |
| dst_mode | input | 3 | Destination addressing mode |
| dst_reg | input | 3 | Destination register number |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle strobe: both descriptors valid |
| src_is_reg | output | 1 | Source operand is a register |
| src_sel | output | 3 | Source register number when src_is_reg |
| src_addr | output | 16 | Source memory address when not src_is_reg |
| dst_is_reg | output | 1 | Destination operand is a register |
| dst_sel | output | 3 | Destination register number when dst_is_reg |
| dst_addr | output | 16 | Destination memory address when not dst_is_reg |
| reg_rd_sel | output | 3 | Register file read select |
| reg_rd_data | input | 16 | Register file read data (combinational) |
| reg_wr_en | output | 1 | Register file write enable |
| reg_wr_sel | output | 3 | Register file write select |
| reg_wr_data | output | 16 | Register file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address (always even) |
| mem_ack | input | 1 | Read completes in this cycle |
| mem_rdata | input | 16 | Read data, valid with mem_ack |

## Verification
The bench builds the block with its default parameters: a 16-bit datapath, eight registers, the stack register at index 6 and the instruction pointer at index 7. With these defaults, the wide-step rule applies to both special registers, and indexed addressing relative to the instruction pointer and immediate post-increment on R7 can both be exercised. The same address table is run once with a memory that answers in the request cycle and once with a memory that answers two cycles late. This exposes any dependence on handshake timing. An odd pointer location and odd pointer values bring the alignment rule into play for both word and byte operands.

// File: rtl/oas_pkg.sv
package oas_pkg;

   typedef enum logic [2:0] {
      AM_REG         = 3'd0,
      AM_REG_IND     = 3'd1,
      AM_POSTINC     = 3'd2,
      AM_POSTINC_IND = 3'd3,
      AM_PREDEC      = 3'd4,
      AM_PREDEC_IND  = 3'd5,
      AM_INDEX       = 3'd6,
      AM_INDEX_IND   = 3'd7
   } amode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BASE,
      ST_IDX_PC,
      ST_IDX_WAIT,
      ST_IDX_ADD,
      ST_PTR_WAIT,
      ST_DONE
   } seq_state_e;

   function automatic logic am_autoinc(input logic [2:0] m);
      return m[2:1] == 2'b01;
   endfunction

   function automatic logic am_autodec(input logic [2:0] m);
      return m[2:1] == 2'b10;
   endfunction

   function automatic logic am_indexed(input logic [2:0] m);
      return m[2:1] == 2'b11;
   endfunction

   // extra pointer read: modes 3, 5, 7
   function automatic logic am_needs_ptr(input logic [2:0] m);
      return m[0] && (m[2] || m[1]);
   endfunction

endpackage

// File: rtl/oas_step_unit.sv
module oas_step_unit #(
   parameter int W      = 16,
   parameter int NREG   = 8,
   parameter int SP_IDX = 6,
   parameter int PC_IDX = 7
) (
   input  logic [$clog2(NREG)-1:0] reg_idx,
   input  logic                    byte_op,
   input  logic                    deferred,
   input  logic                    decrement,
   input  logic [W-1:0]            base,
   output logic [W-1:0]            next_val
);
   localparam int RSEL_W = $clog2(NREG);

   logic [NREG-1:0] wide_mask;
   logic [W-1:0]    inc;

   // registers that always step by a full word
   for (genvar gi = 0; gi < NREG; gi++) begin : g_mask
      if (gi == SP_IDX || gi == PC_IDX) begin : g_wide
         assign wide_mask[gi] = 1'b1;
      end else begin : g_narrow
         assign wide_mask[gi] = 1'b0;
      end
   end

   always_comb begin
      if (wide_mask[reg_idx] || deferred || !byte_op) inc = W'(2);
      else                                           inc = W'(1);
      next_val = decrement ? (base - inc) : (base + inc);
   end

   initial begin
      assert (RSEL_W >= 1) else $error("oas_step_unit: NREG too small");
   end
endmodule

// File: rtl/oas_rd_port.sv
module oas_rd_port #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         issue,
   input  logic [W-1:0] issue_addr,
   output logic         mem_req,
   output logic [W-1:0] mem_addr,
   input  logic         mem_ack,
   input  logic [W-1:0] mem_rdata,
   output logic         rsp_valid,
   output logic [W-1:0] rsp_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req  <= 1'b0;
         mem_addr <= '0;
      end else if (issue) begin
         mem_req  <= 1'b1;
         mem_addr <= issue_addr;
      end else if (mem_req && mem_ack) begin
         mem_req  <= 1'b0;
      end
   end

   assign rsp_valid = mem_req && mem_ack;
   assign rsp_data  = mem_rdata;

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> (!mem_req || mem_ack));

   assert_even_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]);
endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
   import oas_pkg::*;
#(
   parameter int W      = 16,
   parameter int NREG   = 8,
   parameter int SP_IDX = 6,
   parameter int PC_IDX = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         byte_op,
   input  logic [2:0]   src_mode,
   input  logic [2:0]   src_reg,
   input  logic [2:0]   dst_mode,
   input  logic [2:0]   dst_reg,
   output logic         busy,
   output logic         done,
   output logic         src_is_reg,
   output logic [2:0]   src_sel,
   output logic [15:0]  src_addr,
   output logic         dst_is_reg,
   output logic [2:0]   dst_sel,
   output logic [15:0]  dst_addr,
   output logic [2:0]   reg_rd_sel,
   input  logic [15:0]  reg_rd_data,
   output logic         reg_wr_en,
   output logic [2:0]   reg_wr_sel,
   output logic [15:0]  reg_wr_data,
   output logic         mem_req,
   output logic [15:0]  mem_addr,
   input  logic         mem_ack,
   input  logic [15:0]  mem_rdata
);
   localparam int RSEL_W = $clog2(NREG);
   localparam logic [RSEL_W-1:0] PC_SEL = RSEL_W'(PC_IDX);
   localparam logic [W-1:0] NEG1 = {W{1'b1}};
   localparam logic [W-1:0] NEG2 = {{(W-1){1'b1}}, 1'b0};

   seq_state_e        st;
   logic              cur_dst;
   logic              byte_q;
   logic [2:0]        smode_q, dmode_q;
   logic [RSEL_W-1:0] sreg_q, dreg_q;
   logic [W-1:0]      idx_q;

   logic [2:0]        cm;
   logic [RSEL_W-1:0] cr;
   logic [W-1:0]      step_val;
   logic              rsp_valid;
   logic [W-1:0]      rsp_data;

   logic              rec_en, rec_reg;
   logic [W-1:0]      rec_addr, rec_final;
   logic              iss_en;
   logic [W-1:0]      iss_addr, iss_addr_al;
   logic [W-1:0]      ea_sum;

   assign cm = cur_dst ? dmode_q : smode_q;
   assign cr = cur_dst ? dreg_q  : sreg_q;

   oas_step_unit #(.W(W), .NREG(NREG), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_step (
      .reg_idx   (cr),
      .byte_op   (byte_q),
      .deferred  (am_needs_ptr(cm)),
      .decrement (am_autodec(cm)),
      .base      (reg_rd_data),
      .next_val  (step_val)
   );

   oas_rd_port #(.W(W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (iss_en),
      .issue_addr (iss_addr_al),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data)
   );

   assign ea_sum      = reg_rd_data + idx_q;
   assign iss_addr_al = {iss_addr[W-1:1], 1'b0};
   assign rec_final   = byte_q ? rec_addr : {rec_addr[W-1:1], 1'b0};

   // per-state datapath control
   always_comb begin
      rec_en      = 1'b0;
      rec_reg     = 1'b0;
      rec_addr    = reg_rd_data;
      iss_en      = 1'b0;
      iss_addr    = reg_rd_data;
      reg_wr_en   = 1'b0;
      reg_wr_sel  = cr;
      reg_wr_data = step_val;
      reg_rd_sel  = (st == ST_IDX_PC) ? PC_SEL : cr;
      unique case (st)
         ST_BASE: begin
            if (cm == AM_REG) begin
               rec_en  = 1'b1;
               rec_reg = 1'b1;
            end else if (cm == AM_REG_IND) begin
               rec_en = 1'b1;
            end else if (am_autoinc(cm)) begin
               reg_wr_en = 1'b1;
               if (am_needs_ptr(cm)) iss_en = 1'b1;
               else                  rec_en = 1'b1;
            end else if (am_autodec(cm)) begin
               reg_wr_en = 1'b1;
               iss_addr  = step_val;
               rec_addr  = step_val;
               if (am_needs_ptr(cm)) iss_en = 1'b1;
               else                  rec_en = 1'b1;
            end
         end
         ST_IDX_PC: begin
            iss_en      = 1'b1;
            reg_wr_en   = 1'b1;
            reg_wr_sel  = PC_SEL;
            reg_wr_data = reg_rd_data + W'(2);
         end
         ST_IDX_ADD: begin
            iss_addr = ea_sum;
            rec_addr = ea_sum;
            if (am_needs_ptr(cm)) iss_en = 1'b1;
            else                  rec_en = 1'b1;
         end
         ST_PTR_WAIT: begin
            rec_addr = rsp_data;
            rec_en   = rsp_valid;
         end
         default: ;
      endcase
   end

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur_dst <= 1'b0;
         byte_q  <= 1'b0;
         smode_q <= '0;
         dmode_q <= '0;
         sreg_q  <= '0;
         dreg_q  <= '0;
         idx_q   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  byte_q  <= byte_op;
                  smode_q <= src_mode;
                  dmode_q <= dst_mode;
                  sreg_q  <= src_reg[RSEL_W-1:0];
                  dreg_q  <= dst_reg[RSEL_W-1:0];
                  cur_dst <= 1'b0;
                  st      <= ST_BASE;
               end
            end
            ST_BASE: begin
               if (am_indexed(cm)) st <= ST_IDX_PC;
               else if (iss_en)    st <= ST_PTR_WAIT;
               else if (cur_dst)   st <= ST_DONE;
               else begin
                  cur_dst <= 1'b1;
                  st      <= ST_BASE;
               end
            end
            ST_IDX_PC: st <= ST_IDX_WAIT;
            ST_IDX_WAIT: begin
               if (rsp_valid) begin
                  idx_q <= rsp_data;
                  st    <= ST_IDX_ADD;
               end
            end
            ST_IDX_ADD: begin
               if (iss_en)       st <= ST_PTR_WAIT;
               else if (cur_dst) st <= ST_DONE;
               else begin
                  cur_dst <= 1'b1;
                  st      <= ST_BASE;
               end
            end
            ST_PTR_WAIT: begin
               if (rsp_valid) begin
                  if (cur_dst) st <= ST_DONE;
                  else begin
                     cur_dst <= 1'b1;
                     st      <= ST_BASE;
                  end
               end
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // descriptors
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_is_reg <= 1'b0;
         src_sel    <= '0;
         src_addr   <= '0;
         dst_is_reg <= 1'b0;
         dst_sel    <= '0;
         dst_addr   <= '0;
      end else if (rec_en) begin
         if (!cur_dst) begin
            src_is_reg <= rec_reg;
            src_sel    <= 3'(cr);
            src_addr   <= rec_reg ? '0 : rec_final;
         end else begin
            dst_is_reg <= rec_reg;
            dst_sel    <= 3'(cr);
            dst_addr   <= rec_reg ? '0 : rec_final;
         end
      end
   end

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_DONE);

   initial begin
      assert (W == 16) else $error("opnd_addr_seq: ports are 16 bits wide");
      assert (NREG == 8) else $error("opnd_addr_seq: register field is 3 bits");
      assert (SP_IDX < NREG && PC_IDX < NREG) else $error("opnd_addr_seq: special index out of range");
      assert (SP_IDX != PC_IDX) else $error("opnd_addr_seq: SP and PC must differ");
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!reg_wr_en && !mem_req && !done));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_fields_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(smode_q) && $stable(dmode_q) && $stable(byte_q)));

   assert_step_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> ((reg_wr_data - reg_rd_data) == W'(1) || (reg_wr_data - reg_rd_data) == W'(2)
                  || (reg_wr_data - reg_rd_data) == NEG1 || (reg_wr_data - reg_rd_data) == NEG2));

   assert_wide_regs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && (reg_wr_sel == RSEL_W'(SP_IDX) || reg_wr_sel == PC_SEL))
         |-> ((reg_wr_data - reg_rd_data) == W'(2) || (reg_wr_data - reg_rd_data) == NEG2));

   assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !byte_q) |-> ((src_is_reg || !src_addr[0]) && (dst_is_reg || !dst_addr[0])));
endmodule

// File: tb/opnd_addr_seq_test.sv
module opnd_addr_seq_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        bop;
      logic [2:0]  sm;
      logic [2:0]  sr;
      logic [2:0]  dm;
      logic [2:0]  dr;
      logic        s_reg;
      logic [15:0] s_val;
      logic        d_reg;
      logic [15:0] d_val;
      logic [2:0]  ck_r;
      logic [15:0] ck_v;
   } vec_t;

   localparam logic [15:0] INIT [8] = '{16'h1000, 16'h2001, 16'h3000, 16'h4002,
                                        16'h5000, 16'h6000, 16'h7000, 16'h0100};

   // memory word at a = a + 0x0203
   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd0, 3'd1, 3'd0, 3'd2, 1'b1, 16'd1,    1'b1, 16'd2,    3'd2, 16'h3000}, // R2
      '{1'b0, 3'd1, 3'd1, 3'd1, 3'd3, 1'b0, 16'h2000, 1'b0, 16'h4002, 3'd3, 16'h4002}, // R3 R10
      '{1'b1, 3'd1, 3'd1, 3'd1, 3'd0, 1'b0, 16'h2001, 1'b0, 16'h1000, 3'd1, 16'h2001}, // R3 R10
      '{1'b1, 3'd2, 3'd0, 3'd2, 3'd0, 1'b0, 16'h1000, 1'b0, 16'h1001, 3'd0, 16'h1002}, // R9 R6
      '{1'b0, 3'd2, 3'd0, 3'd2, 3'd0, 1'b0, 16'h1000, 1'b0, 16'h1002, 3'd0, 16'h1004}, // R4 R9
      '{1'b1, 3'd4, 3'd6, 3'd4, 3'd2, 1'b0, 16'h6FFE, 1'b0, 16'h2FFF, 3'd6, 16'h6FFE}, // R5 R6
      '{1'b0, 3'd6, 3'd2, 3'd0, 3'd4, 1'b0, 16'h3302, 1'b1, 16'd4,    3'd7, 16'h0102}, // R7
      '{1'b0, 3'd6, 3'd7, 3'd6, 3'd7, 1'b0, 16'h0404, 1'b0, 16'h0408, 3'd7, 16'h0104}, // R7 R9
      '{1'b1, 3'd3, 3'd0, 3'd1, 3'd5, 1'b0, 16'h1203, 1'b0, 16'h6000, 3'd0, 16'h1002}, // R8 R6
      '{1'b0, 3'd5, 3'd3, 3'd7, 3'd1, 1'b0, 16'h4202, 1'b0, 16'h2506, 3'd3, 16'h4000}, // R8 R10
      '{1'b1, 3'd7, 3'd5, 3'd3, 3'd4, 1'b0, 16'h6505, 1'b0, 16'h5203, 3'd4, 16'h5002}, // R8 R10
      '{1'b0, 3'd2, 3'd7, 3'd0, 3'd0, 1'b0, 16'h0100, 1'b1, 16'd0,    3'd7, 16'h0102}  // R4
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, byte_op = 1'b0;
   logic [2:0] src_mode = '0, src_reg = '0, dst_mode = '0, dst_reg = '0;
   logic busy, done, src_is_reg, dst_is_reg, reg_wr_en, mem_req;
   logic [2:0] src_sel, dst_sel, reg_rd_sel, reg_wr_sel;
   logic [15:0] src_addr, dst_addr, reg_rd_data, reg_wr_data, mem_addr;
   logic mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;

   logic [15:0] rf [8];
   logic ld_en = 1'b0;
   int lat_cfg = 0, wcnt = 0;
   int wr_cnt = 0, acc_cnt = 0, odd_cnt = 0;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opnd_addr_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_op(byte_op),
      .src_mode(src_mode), .src_reg(src_reg), .dst_mode(dst_mode), .dst_reg(dst_reg),
      .busy(busy), .done(done),
      .src_is_reg(src_is_reg), .src_sel(src_sel), .src_addr(src_addr),
      .dst_is_reg(dst_is_reg), .dst_sel(dst_sel), .dst_addr(dst_addr),
      .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   assign reg_rd_data = rf[reg_rd_sel];

   always @(posedge clk) begin
      if (ld_en) begin
         for (int i = 0; i < 8; i++) rf[i] <= INIT[i];
      end else if (reg_wr_en) begin
         rf[reg_wr_sel] <= reg_wr_data;
      end
      if (rst_n && reg_wr_en) wr_cnt <= wr_cnt + 1;
      if (mem_req && mem_ack) acc_cnt <= acc_cnt + 1;
      if (mem_req && mem_addr[0]) odd_cnt <= odd_cnt + 1;
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         wcnt    <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (wcnt >= lat_cfg) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_addr + 16'h0203;
            wcnt      <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load_regs();
      @(negedge clk) ld_en = 1'b1;
      @(negedge clk) ld_en = 1'b0;
   endtask

   task automatic issue(input vec_t v);
      byte_op = v.bop; src_mode = v.sm; src_reg = v.sr; dst_mode = v.dm; dst_reg = v.dr;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R11 done seen", 16'(done), 16'd1);
   endtask

   task automatic check_desc(input vec_t v, input string tag);
      chk({tag, " src is_reg"}, 16'(src_is_reg), 16'(v.s_reg));
      if (v.s_reg) chk({tag, " src sel"}, 16'(src_sel), v.s_val);
      else         chk({tag, " src addr"}, src_addr, v.s_val);
      chk({tag, " dst is_reg"}, 16'(dst_is_reg), 16'(v.d_reg));
      if (v.d_reg) chk({tag, " dst sel"}, 16'(dst_sel), v.d_val);
      else         chk({tag, " dst addr"}, dst_addr, v.d_val);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int w0, a0;
      vec_t hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 16'(busy), 16'd0);
      chk("R1 done", 16'(done), 16'd0);
      chk("R1 mem_req", 16'(mem_req), 16'd0);
      chk("R1 reg_wr_en", 16'(reg_wr_en), 16'd0);

      // table walk, immediate and delayed memory
      for (int pass = 0; pass < 2; pass++) begin
         lat_cfg = pass * 2;
         for (int k = 0; k < NV; k++) begin
            load_regs();
            w0 = wr_cnt; a0 = acc_cnt;
            issue(VECS[k]);
            wait_done();
            check_desc(VECS[k], $sformatf("vec%0d lat%0d", k, lat_cfg));
            @(negedge clk);
            chk($sformatf("vec%0d reg R%0d", k, VECS[k].ck_r), rf[VECS[k].ck_r], VECS[k].ck_v);
            if (k == 0) begin
               chk("R2 no reg writes", 16'(wr_cnt - w0), 16'd0);
               chk("R2 no mem reads", 16'(acc_cnt - a0), 16'd0);
            end
            if (k == 1) chk("R3 no reg writes", 16'(wr_cnt - w0), 16'd0);
         end
      end

      // R11: start while busy ignored, single-cycle done, stable descriptors
      lat_cfg = 1;
      load_regs();
      issue(VECS[6]);
      hold = VECS[0]; hold.bop = 1'b1;
      @(negedge clk);
      issue(hold);
      wait_done();
      check_desc(VECS[6], "R11 busy start");
      @(negedge clk);
      chk("R11 done one cycle", 16'(done), 16'd0);
      src_mode = 3'd1; dst_mode = 3'd2;
      repeat (3) @(negedge clk);
      check_desc(VECS[6], "R11 held");
      chk("R1 idle busy", 16'(busy), 16'd0);

      // R10: no odd read address was ever presented
      chk("R10 odd reads", 16'(odd_cnt), 16'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule